// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits behind a floating-point execution path and records the outcome of each completed operation. When an operation finishes, it raises a valid strobe together with a five-bit IEEE exception vector, the current floating-point status register and the program-counter pair of the instruction. The block compares the reported exceptions with the trap-enable mask held in the status register and decides whether the operation traps.

On a trap, the block keeps only the single most important enabled exception in the current-exception field. It also marks the trap type and leaves the program-counter pair where it was. When the operation does not trap, the block copies the full exception vector into the current-exception field and ORs it into the accrued field. It then steps the program-counter pair past the instruction. An operation that reports no exception only clears the current-exception field and advances.

The updated status word, the next PC/NPC and a one-cycle trap pulse are registered. They change in the clock cycle that follows the strobe. Between strobes the registered outputs hold their values.

Top module: `fp_exc_recorder`

## Requirements
- R1: Status register layout: the trap-enable mask is bits 27:23, the accrued field is bits 9:5, the current-exception field is bits 4:0 and the trap-type marker is bit 14. Inside every five-bit field, invalid is bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1 and inexact bit 0.
- R2: A trap is taken when the exception vector and the trap-enable mask share at least one set bit. In that case trap_o is high for exactly the one cycle after the strobe.
- R3: On a trap, the current-exception field holds exactly one bit. This is the highest-priority bit of (exceptions AND mask), in the order invalid, overflow, underflow, divide-by-zero, inexact.
- R4: On a trap, the accrued field is left unchanged and bit 14 is set.
- R5: Without a trap and with a nonzero vector, the current-exception field equals the full vector and the accrued field becomes its old value ORed with the vector.
- R6: Without a trap, pc_o takes npc_i and npc_o takes npc_i + 4.
- R7: On a trap, pc_o and npc_o take pc_i and npc_i unchanged.
- R8: A strobe with an all-zero vector clears the current-exception field, leaves every other status bit as given, does not trap and advances the PC pair as in R6.
- R9: In a cycle without a strobe, status_o, pc_o and npc_o hold their values and trap_o is low.
- R10: Status bits outside the current and accrued fields pass through from status_i unchanged, except bit 14 on a trap. Bit 14 is not cleared when no trap is taken.
- R11: While rst_ni is low, status_o, pc_o, npc_o and trap_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation completed; sample the other inputs |
| exc_i | input | 5 | Reported IEEE exception flags |
| status_i | input | STATUS_W | Status register before the update |
| pc_i | input | PC_W | PC of the completing instruction |
| npc_i | input | PC_W | NPC of the completing instruction |
| status_o | output | STATUS_W | Updated status register |
| trap_o | output | 1 | One-cycle pulse when an IEEE trap is taken |
| pc_o | output | PC_W | Next PC |
| npc_o | output | PC_W | Next NPC |

## Verification
The hardest case to reach is a trap where several enabled exceptions arrive together and disabled exceptions arrive alongside them. In that case the priority reduction must drop bits both for being masked and for losing on priority. The stimulus sweeps all 32 exception vectors against several masks: empty, full, alternating, and one with only the two ends set. It adds random patterns in the unrelated status bits. It also drives trapping strobes back to back and mixes in idle cycles, so that the hold behaviour and the trap pulse width are exercised between and across traps.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;
  localparam int unsigned NFLAG   = 5;
  localparam int unsigned EN_LO   = 23;
  localparam int unsigned ACC_LO  = 5;
  localparam int unsigned CUR_LO  = 0;
  localparam int unsigned TTYPE_B = 14;
  // flag positions inside a field; higher index wins on a trap
  localparam int unsigned FLG_NV  = 4;
  localparam int unsigned FLG_OF  = 3;
  localparam int unsigned FLG_UF  = 2;
  localparam int unsigned FLG_DZ  = 1;
  localparam int unsigned FLG_NX  = 0;
  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/exc_trap_detect.sv
module exc_trap_detect
  import fp_exc_pkg::*;
(
  input  flags_t exc_i,
  input  flags_t en_i,
  output logic   trap_o,
  output flags_t sel_o
);
  flags_t hit;
  assign hit    = exc_i & en_i;
  assign trap_o = |hit;

  // keep highest-index enabled flag
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < int'(NFLAG); i++) begin
      if (hit[i]) sel_o = flags_t'(1) << i;
    end
  end
endmodule

// File: rtl/exc_status_merge.sv
module exc_status_merge
  import fp_exc_pkg::*;
#(
  parameter int unsigned STATUS_W = 32
) (
  input  logic [STATUS_W-1:0] status_i,
  input  flags_t              exc_i,
  input  flags_t              sel_i,
  input  logic                trap_i,
  output logic [STATUS_W-1:0] status_o
);
  flags_t acc_old;
  assign acc_old = status_i[ACC_LO +: NFLAG];

  always_comb begin
    status_o = status_i;
    if (trap_i) begin
      status_o[CUR_LO +: NFLAG] = sel_i;
      status_o[TTYPE_B]         = 1'b1;
    end else begin
      status_o[CUR_LO +: NFLAG] = exc_i;
      status_o[ACC_LO +: NFLAG] = acc_old | exc_i;
    end
  end
endmodule

// File: rtl/pc_advance.sv
module pc_advance #(
  parameter int unsigned PC_W    = 64,
  parameter int unsigned PC_STEP = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  input  logic            adv_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  assign pc_o  = adv_i ? npc_i        : pc_i;
  assign npc_o = adv_i ? npc_i + STEP : npc_i;
endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder
  import fp_exc_pkg::*;
#(
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned PC_W     = 64,
  parameter int unsigned PC_STEP  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [NFLAG-1:0]    exc_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [PC_W-1:0]     npc_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                trap_o,
  output logic [PC_W-1:0]     pc_o,
  output logic [PC_W-1:0]     npc_o
);
  flags_t              en, sel;
  logic                trap;
  logic [STATUS_W-1:0] status_nxt;
  logic [PC_W-1:0]     pc_nxt, npc_nxt;

  assign en = status_i[EN_LO +: NFLAG];

  exc_trap_detect u_detect (
    .exc_i  (exc_i),
    .en_i   (en),
    .trap_o (trap),
    .sel_o  (sel)
  );

  exc_status_merge #(.STATUS_W(STATUS_W)) u_merge (
    .status_i (status_i),
    .exc_i    (exc_i),
    .sel_i    (sel),
    .trap_i   (trap),
    .status_o (status_nxt)
  );

  pc_advance #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
    .pc_i  (pc_i),
    .npc_i (npc_i),
    .adv_i (!trap),
    .pc_o  (pc_nxt),
    .npc_o (npc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      pc_o     <= '0;
      npc_o    <= '0;
      trap_o   <= 1'b0;
    end else begin
      trap_o <= valid_i & trap;
      if (valid_i) begin
        status_o <= status_nxt;
        pc_o     <= pc_nxt;
        npc_o    <= npc_nxt;
      end
    end
  end
endmodule

// File: rtl/fp_exc_recorder_chk.sv
module fp_exc_recorder_chk
  import fp_exc_pkg::*;
#(
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned PC_W     = 64,
  parameter int unsigned PC_STEP  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [NFLAG-1:0]    exc_i,
  input logic [STATUS_W-1:0] status_i,
  input logic [PC_W-1:0]     pc_i,
  input logic [PC_W-1:0]     npc_i,
  input logic [STATUS_W-1:0] status_o,
  input logic                trap_o,
  input logic [PC_W-1:0]     pc_o,
  input logic [PC_W-1:0]     npc_o
);
  // R2
  trap_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(valid_i));

  // R3
  trap_single_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $countones(status_o[CUR_LO +: NFLAG]) == 1);

  // R4
  trap_keeps_accrued_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> status_o[TTYPE_B] && status_o[ACC_LO +: NFLAG] == $past(status_i[ACC_LO +: NFLAG]));

  // R5
  notrap_current_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !trap_o) |-> status_o[CUR_LO +: NFLAG] == $past(exc_i));

  // R6
  notrap_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !trap_o) |-> pc_o == $past(npc_i) && npc_o == $past(npc_i) + PC_W'(PC_STEP));

  // R7
  trap_hold_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> pc_o == $past(pc_i) && npc_o == $past(npc_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(status_o) && $stable(pc_o) && $stable(npc_o) && !trap_o);
endmodule

bind fp_exc_recorder fp_exc_recorder_chk #(
  .STATUS_W (STATUS_W),
  .PC_W     (PC_W),
  .PC_STEP  (PC_STEP)
) u_chk (.*);

// File: tb/fp_exc_recorder_test.sv
module fp_exc_recorder_test;
  localparam int SW = 32;
  localparam int PW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [4:0]    exc = '0;
  logic [SW-1:0] st_in = '0;
  logic [PW-1:0] pc_in = '0, npc_in = '0;
  logic [SW-1:0] st_out;
  logic          trap_out;
  logic [PW-1:0] pc_out, npc_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // model state
  logic [SW-1:0] m_st = '0;
  logic [PW-1:0] m_pc = '0, m_npc = '0;
  logic          m_trap = 0, m_valid = 0;
  logic [4:0]    m_exc = '0;

  always #10 clk = ~clk;

  fp_exc_recorder uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .exc_i(exc),
    .status_i(st_in), .pc_i(pc_in), .npc_i(npc_in),
    .status_o(st_out), .trap_o(trap_out), .pc_o(pc_out), .npc_o(npc_out)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [SW-1:0] other_mask;
    string rc, ra, rb, rp, rt;
    other_mask = ~(SW'(32'h3FF) | (SW'(1) << 14));
    rt = m_valid ? "R2" : "R9";
    rp = !m_valid ? "R9" : (m_trap ? "R7" : "R6");
    rc = !m_valid ? "R9" : (m_trap ? "R3" : (m_exc == 0 ? "R8" : "R5"));
    ra = !m_valid ? "R9" : (m_trap ? "R4" : "R5");
    rb = !m_valid ? "R9" : (m_trap ? "R4" : "R10");
    chk(rt, "trap", 64'(trap_out), 64'(m_trap));
    chk(rp, "pc", pc_out, m_pc);
    chk(rp, "npc", npc_out, m_npc);
    chk(rc, "current", 64'(st_out[4:0]), 64'(m_st[4:0]));
    chk(ra, "accrued", 64'(st_out[9:5]), 64'(m_st[9:5]));
    chk(rb, "ttype", 64'(st_out[14]), 64'(m_st[14]));
    chk("R10", "other", 64'(st_out & other_mask), 64'(m_st & other_mask));
  endtask

  function automatic logic [4:0] pick(logic [4:0] hit);
    int order[5] = '{4, 3, 2, 1, 0};
    foreach (order[k]) if (hit[order[k]]) return 5'(1) << order[k];
    return '0;
  endfunction

  task automatic step(bit v, logic [4:0] e, logic [SW-1:0] s, logic [PW-1:0] p, logic [PW-1:0] n);
    logic [4:0] hit;
    @(negedge clk);
    compare();
    valid = v; exc = e; st_in = s; pc_in = p; npc_in = n;
    @(posedge clk);
    m_valid = v; m_exc = e;
    m_trap = 0;
    if (v) begin
      hit = e & s[27:23];
      m_st = s;
      if (hit != 0) begin
        m_trap = 1;
        m_st[4:0] = pick(hit);
        m_st[14] = 1'b1;
        m_pc = p; m_npc = n;
      end else begin
        m_st[4:0] = e;
        m_st[9:5] = s[9:5] | e;
        m_pc = n; m_npc = n + 64'd4;
      end
    end
  endtask

  function automatic logic [SW-1:0] mk_status(logic [4:0] en, logic [SW-1:0] rnd);
    logic [SW-1:0] s;
    s = rnd;
    s[27:23] = en;
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] masks[4] = '{5'h00, 5'h1F, 5'h0A, 5'h11};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "status", 64'(st_out), 64'd0);
    chk("R11", "trap", 64'(trap_out), 64'd0);
    chk("R11", "pc", pc_out, 64'd0);
    chk("R11", "npc", npc_out, 64'd0);
    rst_n = 1'b1;

    // R1: underflow bit 2 enabled only, several flags raised
    step(1, 5'b00111, mk_status(5'b00100, 32'h0000_4000 ^ 32'h4000), 64'h100, 64'h104);
    step(0, '0, '0, '0, '0);
    chk("R1", "underflow position", 64'(st_out[4:0]), 64'h4);
    chk("R1", "trap mark bit", 64'(st_out[14]), 64'd1);

    foreach (masks[mi]) begin
      for (int e = 0; e < 32; e++) begin
        logic [PW-1:0] p;
        p = 64'(32'h1000 + e * 8 + mi * 1024);
        step(1, 5'(e), mk_status(masks[mi], $urandom()), p, p + 64'd4);
        if (e % 7 == 3) step(0, 5'($urandom()), $urandom(), 64'($urandom()), 64'($urandom()));
      end
    end

    // R8 zero vector with bit14 already set and accrued nonzero
    step(1, 5'b0, 32'h0F80_43FF, 64'h200, 64'h204);
    // back-to-back traps, R3 priority with masked bits mixed in
    step(1, 5'b11111, mk_status(5'b01010, 32'h0000_0000), 64'h300, 64'h304);
    step(1, 5'b10110, mk_status(5'b00011, 32'h0000_0000), 64'h308, 64'h30C);
    step(1, 5'b00001, mk_status(5'b00001, 32'hFFFF_FFFF), 64'h310, 64'h314);
    repeat (3) step(0, 5'b11111, 32'hFFFF_FFFF, 64'hDEAD, 64'hBEEF);
    for (int k = 0; k < 200; k++)
      step(($urandom() % 3) != 0, 5'($urandom()), $urandom(), {$urandom(), $urandom()}, {$urandom(), $urandom()});
    step(0, '0, '0, '0, '0);
    @(negedge clk);
    compare();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule